// File: doc/BRIEF.md
# Byte-Wide ATM Cell Receive Port

This block takes in 53-byte ATM cells from a byte-wide cell bus and stores them in a small cell FIFO. The sender marks the first byte of each cell with a start-of-cell pulse. The port takes a byte only on a clock edge where the active-low enable is low. Incoming bytes go into a staging slot, which is the free FIFO entry at the write pointer. That slot becomes visible to the read side only when the final byte of the cell lands. A cell that a new start-of-cell cuts short is therefore never seen by the reader. Bytes that run past the end of a cell are dropped until the next start-of-cell.

The port tells the sender whether it can take a further whole cell through a cell-available flag. In point-to-point mode the flag is driven on every cycle. In multi-PHY polling mode (parameter `L2_MODE`) the flag is driven only on the cycle after the port's own address was seen on the address bus. On all other cycles the output enable is low, and the pad logic puts the line in high impedance. A software enable bit gates the start of new cells. A cell already in progress is always completed. The core reads cells one byte per handshake. The read side shows a cell-valid flag, the byte index, the data byte and an end-of-cell marker.

Top module: `utopia_cell_rx`

## Requirements
- R1: A cell is committed only once all CELL_BYTES (53) bytes have arrived. The read side then shows rd_cell_valid=1, rd_idx counting 0..52 with the bytes in arrival order, and rd_eoc=1 only at index 52.
- R2: When the clav output is driven, it is 1 exactly when the software enable is set and the stored cells plus any cell in progress number fewer than DEPTH (4).
- R3: When a start-of-cell byte is accepted and its cell will take the last free entry, clav reads 0 in the cycle right after that byte's edge.
- R4: When a start-of-cell arrives before a cell is complete, the partial cell is discarded without trace and the new byte begins a fresh cell.
- R5: After byte 53, any accepted byte without a start-of-cell is ignored until the next start-of-cell.
- R6: With L2_MODE=1, clav_oe is 1 only in the cycle after rx_addr equalled PORT_ADDR at a clock edge. When clav_oe is 0, clav reads 0. With L2_MODE=0, clav_oe is always 1.
- R7: When the software enable is cleared during a cell, that cell still completes and is committed. Start-of-cell bytes that arrive while the enable is clear start nothing, and clav reads 0.
- R8: Data and start-of-cell have no effect on edges where rx_enb_n is 1.
- R9: When all DEPTH entries are full, a start-of-cell is ignored and its whole cell is dropped. Stored cells are unaffected.
- R10: While rd_ready is 0, rd_idx and rd_data hold. The handshake at index 52 removes the cell.
- R11: After reset the FIFO is empty (rd_cell_valid=0) and clav reads 1 with the enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Incoming cell byte |
| rx_soc | input | 1 | Start-of-cell marker for the current byte |
| rx_enb_n | input | 1 | Active-low byte enable |
| rx_addr | input | ADDR_W | Polling address bus (multi-PHY mode) |
| rx_en | input | 1 | Software receive enable |
| rx_clav | output | 1 | Cell space available |
| rx_clav_oe | output | 1 | Output enable for the clav pad |
| rd_cell_valid | output | 1 | A complete cell is at the head of the FIFO |
| rd_data | output | 8 | Byte at rd_idx of the head cell |
| rd_idx | output | IDX_W | Byte index within the head cell |
| rd_eoc | output | 1 | Head byte is the last byte of the cell |
| rd_ready | input | 1 | Core takes the current byte |

## Verification
A wrong byte counter or wrong staging state shows up as a wrong cell at the read side: shifted data, a cell that should have been dropped, or a missing cell. The bench sees this as soon as it drains the FIFO after each scenario. A wrong occupancy count shows up at the clav pin on the cycle after the byte that should have changed it. For this reason the bench samples clav right after the first byte of the cell that fills the FIFO. A wrong poll register shows up on clav_oe one cycle after the address is driven.

// File: rtl/urx_pkg.sv
package urx_pkg;
   localparam int CELL_LEN_DEF = 53;

   typedef enum logic {
      ASM_HUNT = 1'b0,
      ASM_FILL = 1'b1
   } asm_state_e;
endpackage

// File: rtl/urx_assembler.sv
module urx_assembler
   import urx_pkg::*;
#(
   parameter int CELL_BYTES = CELL_LEN_DEF,
   localparam int IDX_W = $clog2(CELL_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_ok,
   input  logic             soc,
   input  logic             sw_en,
   input  logic             space_ok,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic             commit,
   output logic             busy
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

   asm_state_e       state;
   logic [IDX_W-1:0] idx;
   logic             may_start;

   assign may_start = sw_en && space_ok;
   assign busy      = (state == ASM_FILL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ASM_HUNT;
         idx   <= '0;
      end else if (byte_ok) begin
         if (soc) begin
            if (may_start) begin
               state <= ASM_FILL;
               idx   <= IDX_W'(1);
            end else begin
               state <= ASM_HUNT;
               idx   <= '0;
            end
         end else if (state == ASM_FILL) begin
            if (idx == LAST) begin
               state <= ASM_HUNT;
               idx   <= '0;
            end else begin
               idx <= idx + IDX_W'(1);
            end
         end
      end
   end

   always_comb begin
      wr_en  = 1'b0;
      wr_idx = idx;
      commit = 1'b0;
      if (byte_ok) begin
         if (soc) begin
            wr_en  = may_start;
            wr_idx = '0;
         end else if (state == ASM_FILL) begin
            wr_en  = 1'b1;
            commit = (idx == LAST);
         end
      end
   end
endmodule

// File: rtl/urx_cell_store.sv
module urx_cell_store
   import urx_pkg::*;
#(
   parameter int DEPTH      = 4,
   parameter int CELL_BYTES = CELL_LEN_DEF,
   localparam int IDX_W = $clog2(CELL_BYTES),
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic             commit,
   input  logic             rd_ready,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             rd_eoc,
   output logic [CNT_W-1:0] cell_cnt
);
   localparam logic [IDX_W-1:0] LAST    = IDX_W'(CELL_BYTES - 1);
   localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);

   logic [7:0]       mem [DEPTH][CELL_BYTES];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             pop;

   function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
      return (p == PTR_TOP) ? '0 : p + PTR_W'(1);
   endfunction

   assign rd_valid = (cell_cnt != '0);
   assign rd_data  = mem[rd_ptr][rd_idx];
   assign rd_eoc   = rd_valid && (rd_idx == LAST);
   assign pop      = rd_eoc && rd_ready;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr][wr_idx] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         rd_idx   <= '0;
         cell_cnt <= '0;
      end else begin
         if (commit) wr_ptr <= ptr_next(wr_ptr);
         if (pop) begin
            rd_ptr <= ptr_next(rd_ptr);
            rd_idx <= '0;
         end else if (rd_valid && rd_ready) begin
            rd_idx <= rd_idx + IDX_W'(1);
         end
         case ({commit, pop})
            2'b10:   cell_cnt <= cell_cnt + CNT_W'(1);
            2'b01:   cell_cnt <= cell_cnt - CNT_W'(1);
            default: cell_cnt <= cell_cnt;
         endcase
      end
   end
endmodule

// File: rtl/urx_clav_drive.sv
module urx_clav_drive #(
   parameter int              DEPTH     = 4,
   parameter int              ADDR_W    = 5,
   parameter logic [ADDR_W-1:0] PORT_ADDR = '0,
   parameter bit              L2_MODE   = 1'b0,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  cell_cnt,
   input  logic              busy,
   input  logic              sw_en,
   output logic              clav,
   output logic              clav_oe
);
   logic room;

   assign room = sw_en && ((int'(cell_cnt) + int'(busy)) < DEPTH);

   generate
      if (L2_MODE) begin : g_polled
         logic poll_hit;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) poll_hit <= 1'b0;
            else        poll_hit <= (addr == PORT_ADDR);
         end
         assign clav_oe = poll_hit;
         assign clav    = poll_hit && room;
      end else begin : g_direct
         logic unused_addr;
         assign unused_addr = ^addr;
         assign clav_oe = 1'b1;
         assign clav    = room;
      end
   endgenerate
endmodule

// File: rtl/utopia_cell_rx.sv
module utopia_cell_rx
   import urx_pkg::*;
#(
   parameter int                DEPTH      = 4,
   parameter int                CELL_BYTES = CELL_LEN_DEF,
   parameter int                ADDR_W     = 5,
   parameter logic [ADDR_W-1:0] PORT_ADDR  = '0,
   parameter bit                L2_MODE    = 1'b0,
   localparam int IDX_W = $clog2(CELL_BYTES),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        rx_data,
   input  logic              rx_soc,
   input  logic              rx_enb_n,
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic              rx_en,
   output logic              rx_clav,
   output logic              rx_clav_oe,
   output logic              rd_cell_valid,
   output logic [7:0]        rd_data,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              rd_eoc,
   input  logic              rd_ready
);
   generate
      if (DEPTH < 1 || DEPTH > 64) begin : g_bad_depth
         $error("DEPTH must lie in 1..64");
      end
      if (CELL_BYTES < 2) begin : g_bad_cell
         $error("CELL_BYTES must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   logic             byte_ok;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic             commit;
   logic             busy;
   logic [CNT_W-1:0] cell_cnt;
   logic             space_ok;

   assign byte_ok  = !rx_enb_n;
   assign space_ok = (int'(cell_cnt) < DEPTH);

   urx_assembler #(.CELL_BYTES(CELL_BYTES)) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_ok  (byte_ok),
      .soc      (rx_soc),
      .sw_en    (rx_en),
      .space_ok (space_ok),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .commit   (commit),
      .busy     (busy)
   );

   urx_cell_store #(.DEPTH(DEPTH), .CELL_BYTES(CELL_BYTES)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (rx_data),
      .commit   (commit),
      .rd_ready (rd_ready),
      .rd_valid (rd_cell_valid),
      .rd_data  (rd_data),
      .rd_idx   (rd_idx),
      .rd_eoc   (rd_eoc),
      .cell_cnt (cell_cnt)
   );

   urx_clav_drive #(
      .DEPTH     (DEPTH),
      .ADDR_W    (ADDR_W),
      .PORT_ADDR (PORT_ADDR),
      .L2_MODE   (L2_MODE)
   ) u_clav (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (rx_addr),
      .cell_cnt (cell_cnt),
      .busy     (busy),
      .sw_en    (rx_en),
      .clav     (rx_clav),
      .clav_oe  (rx_clav_oe)
   );
endmodule

// File: rtl/urx_checker.sv
module urx_checker #(
   parameter int                DEPTH     = 4,
   parameter int                ADDR_W    = 5,
   parameter logic [ADDR_W-1:0] PORT_ADDR = '0,
   parameter bit                L2_MODE   = 1'b0,
   parameter int                IDX_W     = 6,
   parameter int                CNT_W     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_soc,
   input logic              rx_enb_n,
   input logic [ADDR_W-1:0] rx_addr,
   input logic              rx_clav,
   input logic              rx_clav_oe,
   input logic              rd_cell_valid,
   input logic [7:0]        rd_data,
   input logic [IDX_W-1:0]  rd_idx,
   input logic              rd_eoc,
   input logic              rd_ready,
   input logic [CNT_W-1:0]  cell_cnt,
   input logic              busy
);
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cell_cnt) <= DEPTH); // R9

   AST_EOC_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rd_eoc |-> rd_cell_valid); // R1

   AST_VALID_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_cell_valid) |-> $past(!rx_enb_n && !rx_soc)); // R1

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cell_valid && !rd_ready) |=> ($stable(rd_idx) && $stable(rd_data))); // R10

   AST_IDLE_BYTE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_enb_n && !rd_ready) |=> ($stable(cell_cnt) && $stable(busy))); // R8

   AST_NO_ROOM_NO_CLAV: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'(cell_cnt) + int'(busy)) >= DEPTH) |-> !rx_clav); // R2

   AST_L2_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (L2_MODE && ($past(rx_addr) != PORT_ADDR)) |-> !rx_clav_oe); // R6

   AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_clav_oe |-> !rx_clav); // R6
endmodule

bind utopia_cell_rx urx_checker #(
   .DEPTH     (DEPTH),
   .ADDR_W    (ADDR_W),
   .PORT_ADDR (PORT_ADDR),
   .L2_MODE   (L2_MODE),
   .IDX_W     (IDX_W),
   .CNT_W     (CNT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_soc        (rx_soc),
   .rx_enb_n      (rx_enb_n),
   .rx_addr       (rx_addr),
   .rx_clav       (rx_clav),
   .rx_clav_oe    (rx_clav_oe),
   .rd_cell_valid (rd_cell_valid),
   .rd_data       (rd_data),
   .rd_idx        (rd_idx),
   .rd_eoc        (rd_eoc),
   .rd_ready      (rd_ready),
   .cell_cnt      (cell_cnt),
   .busy          (busy)
);

// File: tb/utopia_cell_rx_tb.sv
module utopia_cell_rx_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 4;
   localparam int CELL       = 53;
   localparam int ADDR_W     = 5;
   localparam logic [ADDR_W-1:0] MY_ADDR = 5'd9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [7:0]        rx_data = '0;
   logic              rx_soc = 1'b0;
   logic              rx_enb_n = 1'b1;
   logic [ADDR_W-1:0] rx_addr = '0;
   logic              rx_en = 1'b1;
   logic              rd_ready = 1'b0;

   logic       clav, clav_oe, cvalid, eoc;
   logic [7:0] rdata;
   logic [5:0] ridx;
   logic       l2_clav, l2_oe, l2_valid, l2_eoc;
   logic [7:0] l2_data;
   logic [5:0] l2_idx;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   utopia_cell_rx #(.DEPTH(DEPTH), .CELL_BYTES(CELL), .ADDR_W(ADDR_W),
                    .PORT_ADDR(MY_ADDR), .L2_MODE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_soc(rx_soc),
      .rx_enb_n(rx_enb_n), .rx_addr(rx_addr), .rx_en(rx_en),
      .rx_clav(clav), .rx_clav_oe(clav_oe), .rd_cell_valid(cvalid),
      .rd_data(rdata), .rd_idx(ridx), .rd_eoc(eoc), .rd_ready(rd_ready));

   utopia_cell_rx #(.DEPTH(DEPTH), .CELL_BYTES(CELL), .ADDR_W(ADDR_W),
                    .PORT_ADDR(MY_ADDR), .L2_MODE(1'b1)) u_dut_l2 (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_soc(rx_soc),
      .rx_enb_n(rx_enb_n), .rx_addr(rx_addr), .rx_en(rx_en),
      .rx_clav(l2_clav), .rx_clav_oe(l2_oe), .rd_cell_valid(l2_valid),
      .rd_data(l2_data), .rd_idx(l2_idx), .rd_eoc(l2_eoc), .rd_ready(rd_ready));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input logic [7:0] base, input int i);
      return base + 8'(i * 3);
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic push(input logic [7:0] d, input logic s);
      rx_enb_n = 1'b0;
      rx_data  = d;
      rx_soc   = s;
      tick();
      rx_enb_n = 1'b1;
      rx_soc   = 1'b0;
   endtask

   task automatic send_bytes(input logic [7:0] base, input int first, input int last);
      for (int i = first; i <= last; i++) push(pat(base, i), i == 0);
   endtask

   task automatic read_cell(input logic [7:0] base, input string req);
      int bad = 0;
      int act_bad = 0;
      int exp_bad = 0;
      for (int i = 0; i < CELL; i++) begin
         if (bad == 0 && (!cvalid || int'(ridx) != i || rdata != pat(base, i) ||
                          eoc != (i == CELL - 1))) begin
            bad = 1;
            act_bad = int'(rdata);
            exp_bad = int'(pat(base, i));
            $display("FAIL %s: byte %0d valid=%0d idx=%0d eoc=%0d", req, i, cvalid, ridx, eoc);
         end
         rd_ready = 1'b1;
         tick();
      end
      rd_ready = 1'b0;
      checks++;
      if (bad != 0) begin
         errors++;
         $display("FAIL %s: cell data actual=%0d expected=%0d", req, act_bad, exp_bad);
      end
   endtask

   task automatic t_reset();
      chk("R11 valid after reset", int'(cvalid), 0);
      chk("R11 clav after reset", int'(clav), 1);
      chk("R6 clav_oe level1", int'(clav_oe), 1);
   endtask

   task automatic t_single();
      send_bytes(8'h10, 0, CELL - 1);
      chk("R1 valid after full cell", int'(cvalid), 1);
      read_cell(8'h10, "R1");
      chk("R1 empty after read", int'(cvalid), 0);
   endtask

   task automatic t_fill();
      for (int c = 0; c < 3; c++) send_bytes(8'(8'h20 + c * 16), 0, CELL - 1);
      chk("R2 clav with one entry free", int'(clav), 1);
      push(pat(8'h50, 0), 1'b1);
      chk("R3 clav after first byte of last cell", int'(clav), 0);
      send_bytes(8'h50, 1, CELL - 1);
      chk("R2 clav when full", int'(clav), 0);
      send_bytes(8'h90, 0, CELL - 1);
      for (int c = 0; c < 3; c++) begin
         read_cell(8'(8'h20 + c * 16), "R9");
         if (c == 0) chk("R2 clav after one read", int'(clav), 1);
      end
      read_cell(8'h50, "R9");
      chk("R9 overflow cell dropped", int'(cvalid), 0);
   endtask

   task automatic t_short();
      send_bytes(8'hA0, 0, 19);
      send_bytes(8'hB1, 0, CELL - 1);
      read_cell(8'hB1, "R4");
      chk("R4 partial cell gone", int'(cvalid), 0);
   endtask

   task automatic t_long();
      send_bytes(8'hC2, 0, CELL - 1);
      for (int i = 0; i < 10; i++) push(8'hEE, 1'b0);
      send_bytes(8'hD3, 0, CELL - 1);
      read_cell(8'hC2, "R5");
      read_cell(8'hD3, "R5");
      chk("R5 no tail cell", int'(cvalid), 0);
   endtask

   task automatic t_gate();
      send_bytes(8'h33, 0, 4);
      rx_enb_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         rx_data = 8'h5A;
         rx_soc  = (i % 2) == 0;
         tick();
      end
      rx_soc = 1'b0;
      send_bytes(8'h33, 5, CELL - 1);
      read_cell(8'h33, "R8");
      chk("R8 single cell only", int'(cvalid), 0);
   endtask

   task automatic t_enable();
      send_bytes(8'h44, 0, 9);
      rx_en = 1'b0;
      tick();
      chk("R7 clav low while disabled", int'(clav), 0);
      send_bytes(8'h44, 10, CELL - 1);
      chk("R7 cell in progress committed", int'(cvalid), 1);
      send_bytes(8'h77, 0, CELL - 1);
      read_cell(8'h44, "R7");
      chk("R7 new cell refused", int'(cvalid), 0);
      rx_en = 1'b1;
      tick();
   endtask

   task automatic t_stall();
      send_bytes(8'h61, 0, CELL - 1);
      for (int i = 0; i < 10; i++) begin
         rd_ready = 1'b1;
         tick();
      end
      rd_ready = 1'b0;
      for (int i = 0; i < 4; i++) tick();
      chk("R10 idx held while stalled", int'(ridx), 10);
      chk("R10 data held while stalled", int'(rdata), int'(pat(8'h61, 10)));
      for (int i = 10; i < CELL; i++) begin
         rd_ready = 1'b1;
         tick();
      end
      rd_ready = 1'b0;
      chk("R10 cell removed after last byte", int'(cvalid), 0);
   endtask

   task automatic t_poll();
      chk("R6 l2 silent before poll", int'(l2_oe), 0);
      rx_addr = MY_ADDR;
      tick();
      chk("R6 l2 driven after own addr", int'(l2_oe), 1);
      chk("R6 l2 clav value", int'(l2_clav), 1);
      rx_addr = 5'd3;
      tick();
      chk("R6 l2 silent after other addr", int'(l2_oe), 0);
      chk("R6 l2 clav low undriven", int'(l2_clav), 0);
      chk("R6 level1 still driven", int'(clav_oe), 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rx_addr = 5'd1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_fill();
      t_short();
      t_long();
      t_gate();
      t_enable();
      t_stall();
      t_poll();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule